// File: doc/BRIEF.md
# Configurable Output Cell for a Sum-of-Products Array

This block is one output cell of a programmable sum-of-products device. It takes the OR of the product terms allocated to it, its own output-enable product term, and two terms shared by all cells: a clocked set and an unclocked clear. A two-bit mode input selects whether the pin is driven from a D flip-flop or straight from the sum term, and whether the pin is active-high or active-low.

The flip-flop has a test preload path that loads any value regardless of the array. It also has a power-up clear input. The cell produces the pin's data and enable as separate signals, so the pad itself is modelled outside. It also chooses which signal is fed back into the array. Registered cells feed back the flip-flop state. Combinational cells feed back the pin, so a disabled pin can serve as an extra array input.

Top module: `olmc_cell`

## Requirements
- R1: With `cfg_mode` = 2'b11 (combinational, active-high), `pad_out` equals `sum_term` with no clock involved.
- R2: With `cfg_mode` = 2'b10 (combinational, active-low), `pad_out` equals the inverse of `sum_term`.
- R3: With `cfg_mode[1]` = 0 (registered), the flip-flop captures `sum_term` on each rising clock edge. `pad_out` then shows the stored bit when `cfg_mode[0]` = 1 and its inverse when `cfg_mode[0]` = 0.
- R4: When `sync_set` is 1 at a rising edge, the stored bit becomes 1 on that edge. The pin level after the set follows R3's polarity rule.
- R5: While `async_rst` is 1, the stored bit is 0 at once, with no clock edge needed. This holds even when `sync_set` or `preload_en` is also 1.
- R6: While `por_n` is 0, the stored bit is cleared. A registered active-low pin therefore reads 1 and a registered active-high pin reads 0.
- R7: When `preload_en` is 1 at a rising edge and no clear is active, the stored bit takes `preload_val`. This has priority over `sync_set` and over capture of `sum_term`.
- R8: `pad_oe` equals `oe_term` in every mode.
- R9: `fb_out` carries the stored bit when `cfg_mode[1]` = 0 and carries `pad_in` when `cfg_mode[1]` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising edge |
| por_n | input | 1 | Power-up clear, active low, asynchronous |
| sum_term | input | 1 | OR of this cell's product terms |
| oe_term | input | 1 | Output-enable product term |
| sync_set | input | 1 | Shared synchronous set term |
| async_rst | input | 1 | Shared asynchronous clear term |
| cfg_mode | input | 2 | Bit 1: 1 combinational, 0 registered; bit 0: 1 active-high, 0 active-low |
| preload_en | input | 1 | Test preload request, taken on the rising edge |
| preload_val | input | 1 | Value loaded by a preload |
| pad_in | input | 1 | Level sensed on the pin |
| pad_out | output | 1 | Data driven toward the pin |
| pad_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback into the array |

## Verification
The clocked properties assume that `async_rst` and `por_n` change only between clock edges and stay stable across any edge at which they are sampled. A clear that rises and falls between two edges would wipe a captured value that the edge-relative checks expect to see. The random stimulus therefore changes every input, including both clears, only at the falling edge. As a result, each level is held across a full rising edge. The directed cases cover the combinations whose outcome is decided by priority: clear with set, clear with preload, and set with preload.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

   typedef enum logic [1:0] {
      MODE_REG_LOW   = 2'b00,
      MODE_REG_HIGH  = 2'b01,
      MODE_COMB_LOW  = 2'b10,
      MODE_COMB_HIGH = 2'b11
   } olmc_mode_e;

   typedef struct packed {
      logic registered;
      logic active_high;
   } olmc_cfg_t;

   localparam int unsigned MODE_W = 2;

   function automatic olmc_cfg_t decode_mode(input logic [MODE_W-1:0] bits);
      olmc_cfg_t c;
      c.registered  = ~bits[1];
      c.active_high =  bits[0];
      return c;
   endfunction

endpackage

// File: rtl/olmc_mode_dec.sv
module olmc_mode_dec
   import olmc_pkg::*;
(
   input  logic [MODE_W-1:0] mode_bits,
   output olmc_cfg_t         cfg
);

   always_comb begin
      cfg = decode_mode(mode_bits);
   end

endmodule

// File: rtl/olmc_store.sv
module olmc_store #(
   parameter int PRELOAD_EN = 1,
   parameter int SET_EN     = 1
) (
   input  logic clk,
   input  logic por_n,
   input  logic async_clr,
   input  logic d,
   input  logic set_req,
   input  logic pl_en,
   input  logic pl_val,
   output logic q
);

   logic after_set;
   logic nxt;

   generate
      if (SET_EN != 0) begin : g_set
         always_comb after_set = set_req ? 1'b1 : d;
      end else begin : g_noset
         logic unused_set;
         always_comb begin
            unused_set = set_req;
            after_set  = d;
         end
      end

      if (PRELOAD_EN != 0) begin : g_pl
         always_comb nxt = pl_en ? pl_val : after_set;
      end else begin : g_nopl
         logic unused_pl;
         always_comb begin
            unused_pl = pl_en ^ pl_val;
            nxt       = after_set;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n or posedge async_clr) begin
      if (!por_n) begin
         q <= 1'b0;
      end else if (async_clr) begin
         q <= 1'b0;
      end else begin
         q <= nxt;
      end
   end

endmodule

// File: rtl/olmc_route.sv
module olmc_route
   import olmc_pkg::*;
(
   input  olmc_cfg_t cfg,
   input  logic      q,
   input  logic      sum,
   input  logic      oe,
   input  logic      pin_level,
   output logic      drv_data,
   output logic      drv_en,
   output logic      fb
);

   logic pre_pol;

   always_comb begin
      pre_pol  = cfg.registered ? q : sum;
      drv_data = cfg.active_high ? pre_pol : ~pre_pol;
      drv_en   = oe;
      fb       = cfg.registered ? q : pin_level;
   end

endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
   import olmc_pkg::*;
#(
   parameter int PRELOAD_EN = 1,
   parameter int SET_EN     = 1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sum_term,
   input  logic              oe_term,
   input  logic              sync_set,
   input  logic              async_rst,
   input  logic [MODE_W-1:0] cfg_mode,
   input  logic              preload_en,
   input  logic              preload_val,
   input  logic              pad_in,
   output logic              pad_out,
   output logic              pad_oe,
   output logic              fb_out
);

   generate
      if (PRELOAD_EN != 0 && PRELOAD_EN != 1) begin : g_bad_pl
         $error("olmc_cell: PRELOAD_EN must be 0 or 1");
      end
      if (SET_EN != 0 && SET_EN != 1) begin : g_bad_set
         $error("olmc_cell: SET_EN must be 0 or 1");
      end
   endgenerate

   olmc_cfg_t cfg;
   logic      q;

   olmc_mode_dec u_dec (
      .mode_bits (cfg_mode),
      .cfg       (cfg)
   );

   olmc_store #(
      .PRELOAD_EN (PRELOAD_EN),
      .SET_EN     (SET_EN)
   ) u_store (
      .clk       (clk),
      .por_n     (por_n),
      .async_clr (async_rst),
      .d         (sum_term),
      .set_req   (sync_set),
      .pl_en     (preload_en),
      .pl_val    (preload_val),
      .q         (q)
   );

   olmc_route u_route (
      .cfg       (cfg),
      .q         (q),
      .sum       (sum_term),
      .oe        (oe_term),
      .pin_level (pad_in),
      .drv_data  (pad_out),
      .drv_en    (pad_oe),
      .fb        (fb_out)
   );

endmodule

// File: rtl/olmc_cell_chk.sv
module olmc_cell_chk #(
   parameter int PRELOAD_EN = 1,
   parameter int SET_EN     = 1
) (
   input logic       clk,
   input logic       por_n,
   input logic       sum_term,
   input logic       oe_term,
   input logic       sync_set,
   input logic       async_rst,
   input logic [1:0] cfg_mode,
   input logic       preload_en,
   input logic       preload_val,
   input logic       pad_in,
   input logic       pad_out,
   input logic       pad_oe,
   input logic       fb_out
);

   logic unused_chk;
   always_comb unused_chk = preload_val ^ pad_in ^ sum_term;

   assert_comb_high_R1: assert property (@(posedge clk)
      (cfg_mode == 2'b11) |-> (pad_out == sum_term));

   assert_comb_low_R2: assert property (@(posedge clk)
      (cfg_mode == 2'b10) |-> (pad_out == !sum_term));

   assert_capture_R3: assert property (@(posedge clk) disable iff (!por_n || async_rst)
      ($past(por_n && !async_rst && !preload_en && !sync_set) && cfg_mode == 2'b01)
      |-> (pad_out == $past(sum_term)));

   generate
      if (SET_EN != 0) begin : g_set_chk
         assert_sync_set_R4: assert property (@(posedge clk) disable iff (!por_n || async_rst)
            ($past(por_n && !async_rst && !preload_en && sync_set) && !cfg_mode[1])
            |-> fb_out);
      end
      if (PRELOAD_EN != 0) begin : g_pl_chk
         assert_preload_R7: assert property (@(posedge clk) disable iff (!por_n || async_rst)
            ($past(por_n && !async_rst && preload_en) && !cfg_mode[1])
            |-> (fb_out == $past(preload_val)));
      end
   endgenerate

   assert_async_clear_R5: assert property (@(posedge clk)
      (async_rst && !cfg_mode[1]) |-> !fb_out);

   assert_power_up_R6: assert property (@(posedge clk)
      (!por_n && $past(!por_n) && cfg_mode == 2'b00) |-> pad_out);

   assert_enable_R8: assert property (@(posedge clk)
      pad_oe == oe_term);

   assert_feedback_pin_R9: assert property (@(posedge clk)
      cfg_mode[1] |-> (fb_out == pad_in));

endmodule

bind olmc_cell olmc_cell_chk #(.PRELOAD_EN(PRELOAD_EN), .SET_EN(SET_EN)) u_chk (.*);

// File: tb/olmc_cell_tb.sv
module olmc_cell_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 600;
   localparam int SEED       = 1234;

   logic       clk = 1'b0;
   logic       por_n, sum_term, oe_term, sync_set, async_rst;
   logic [1:0] cfg_mode;
   logic       preload_en, preload_val, pad_in;
   logic       pad_out, pad_oe, fb_out;

   int checks = 0;
   int fails  = 0;
   logic  mq;
   string tag_q;

   always #(CLK_PERIOD/2) clk = ~clk;

   olmc_cell u_dut (
      .clk(clk), .por_n(por_n), .sum_term(sum_term), .oe_term(oe_term),
      .sync_set(sync_set), .async_rst(async_rst), .cfg_mode(cfg_mode),
      .preload_en(preload_en), .preload_val(preload_val), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .fb_out(fb_out)
   );

   function automatic logic exp_pin(input logic [1:0] m, input logic q, input logic s);
      logic v;
      v = m[1] ? s : q;
      return m[0] ? v : ~v;
   endfunction

   function automatic logic exp_fb(input logic [1:0] m, input logic q, input logic p);
      return m[1] ? p : q;
   endfunction

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all();
      string t;
      if (!por_n)          t = "R6";
      else if (cfg_mode[1]) t = cfg_mode[0] ? "R1" : "R2";
      else                 t = tag_q;
      chk(t, pad_out, exp_pin(cfg_mode, mq, sum_term));
      chk("R8", pad_oe, oe_term);
      chk(cfg_mode[1] ? "R9" : t, fb_out, exp_fb(cfg_mode, mq, pad_in));
   endtask

   task automatic model_edge();
      if (!por_n)          begin mq = 1'b0;        tag_q = "R6"; end
      else if (async_rst)  begin mq = 1'b0;        tag_q = "R5"; end
      else if (preload_en) begin mq = preload_val; tag_q = "R7"; end
      else if (sync_set)   begin mq = 1'b1;        tag_q = "R4"; end
      else                 begin mq = sum_term;    tag_q = "R3"; end
   endtask

   task automatic cycle();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      #1;
      check_all();
   endtask

   task automatic quiet();
      sync_set = 0; async_rst = 0; preload_en = 0; preload_val = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(SEED));
      por_n = 0; quiet(); sum_term = 1; oe_term = 0; pad_in = 0;
      cfg_mode = 2'b00; mq = 1'b0; tag_q = "R3";
      // R6: power-up clear, active-low registered pin reads high
      cycle();
      chk("R6", pad_out, 1'b1);
      cfg_mode = 2'b01; #1;
      chk("R6", pad_out, 1'b0);
      @(negedge clk); por_n = 1;

      // R3: capture sum
      sum_term = 1; cycle();
      chk("R3", pad_out, 1'b1);
      cfg_mode = 2'b00; #1; chk("R3", pad_out, 1'b0);

      // R7: preload beats set and D
      @(negedge clk); preload_en = 1; preload_val = 0; sync_set = 1; sum_term = 1;
      cycle();
      chk("R7", fb_out, 1'b0);

      // R4: set beats D
      @(negedge clk); quiet(); sync_set = 1; sum_term = 0;
      cycle();
      chk("R4", fb_out, 1'b1);
      chk("R4", pad_out, 1'b0);

      // R5: immediate clear without a clock, winning over set and preload
      @(negedge clk); quiet(); sum_term = 1;
      #1; async_rst = 1; sync_set = 1; preload_en = 1; preload_val = 1; mq = 1'b0; #1;
      chk("R5", fb_out, 1'b0);
      cycle();
      chk("R5", fb_out, 1'b0);
      @(negedge clk); quiet(); #1;

      // R1/R2/R9: combinational modes, feedback from pin
      cfg_mode = 2'b11; oe_term = 0; pad_in = 1; sum_term = 0; #1;
      chk("R1", pad_out, 1'b0);
      chk("R9", fb_out, 1'b1);
      cfg_mode = 2'b10; #1;
      chk("R2", pad_out, 1'b1);
      oe_term = 1; #1; chk("R8", pad_oe, 1'b1);

      // constrained random
      for (int i = 0; i < N_RANDOM; i++) begin
         @(negedge clk);
         cfg_mode    = 2'($urandom_range(0, 3));
         sum_term    = 1'($urandom_range(0, 1));
         oe_term     = 1'($urandom_range(0, 1));
         pad_in      = 1'($urandom_range(0, 1));
         preload_en  = ($urandom_range(0, 7) == 0);
         preload_val = 1'($urandom_range(0, 1));
         sync_set    = ($urandom_range(0, 5) == 0);
         async_rst   = ($urandom_range(0, 15) == 0);
         por_n       = ($urandom_range(0, 63) != 0);
         #1;
         if (!por_n || async_rst) begin
            mq    = 1'b0;
            tag_q = por_n ? "R5" : "R6";
         end
         check_all();
         cycle();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule